// File: doc/BRIEF.md
# Sine Synthesizer with Phase Accumulator and Pulse-Width Output

This block produces a sine wave by direct digital synthesis. A 32-bit phase accumulator steps once per pulse-width period, and its upper eight bits select one of 256 sine samples. Each sample becomes the duty value of the next pulse-width period. An external low-pass filter turns the pulse train into an analog sine. Bit 31 of the accumulator is also driven out as a square wave at the same frequency.

The synthesized frequency comes from a 10-bit code that arrives on a valid/ready input stream, for example from an analog converter that reads a control voltage. An accepted code sits in a one-entry holding stage. It moves into the frequency word at the next period boundary, so accepting a code never delays an accumulator update. Back-pressure rule: `code_ready` falls in the cycle after a transfer and stays low until the next period boundary frees the holding stage. A producer keeps `code_valid` and `code_data` steady until it sees `code_ready` high at a clock edge.

The period length is programmable through a plain write port.

Top module: `dds_pwm_synth`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls:
  - `tbl_addr` is 0, `square_out` is 0, `pwm_out` is 0, `code_ready` is 1 and `period_start` is 0.
  - The period register holds 0x50.
  - A fresh reset brings all of this back at any time.
- R2: A period lasts (P+1)*4 clocks, where P is the period register. This is 324 clocks for P = 0x50. The first period after reset has the same length. `period_start` is high for exactly the first clock of every period except the first period after reset.
- R3: In every period, `pwm_out` is high for the first D clocks and low for the rest, where D is that period's duty value. D is 0 in the first period after reset.
- R4: The duty value of a period is the table sample at the `tbl_addr` value that held during the previous period. The duty value changes only at a period boundary.
- R5: The table sample at address a is round(126 + 115*sin(2*pi*a/256)), rounded to the nearest integer. Samples therefore span 11 to 241.
- R6: At each period boundary the accumulator adds (F << 13) + 1, modulo 2^32, where F is the frequency code in effect. `tbl_addr` is accumulator bits 31:24. The accumulator does not change at any other time, and each step is at least 1.
- R7: A code transfers on a rising edge where `code_valid` and `code_ready` are both high. After a transfer, `code_ready` stays low until the next boundary, and input offered in that time is ignored. At that boundary, the step still uses the previous F, and the held code becomes F for the following boundaries.
- R8: `square_out` equals accumulator bit 31, that is, bit 7 of `tbl_addr`.
- R9: A cycle with `period_we` high loads `period_din` into the period register. The new value sets where the period ends from the next cycle on. If the counter is already past the new end, the period ends on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_valid | input | 1 | Frequency code offered |
| code_data | input | 10 | Frequency code |
| code_ready | output | 1 | Holding stage empty |
| period_we | input | 1 | Period register write strobe |
| period_din | input | 8 | New period register value |
| pwm_out | output | 1 | Pulse-width modulated sine |
| square_out | output | 1 | Accumulator MSB |
| tbl_addr | output | 8 | Current table address (accumulator bits 31:24) |
| period_start | output | 1 | First clock of a period |

## Verification
The bench follows a model accumulator across many periods and a string of codes. This catches a design that skips the +1, a design that uses a new code at the very boundary that transfers it instead of one period later, and a design that takes the duty from the freshly updated address instead of the previous one. A code that transfers mid-period is followed by changed data held on the input while `code_ready` is low. A design that overwrote its holding stage would then follow the wrong code. The bench counts the first, unannounced period after reset, which must have zero duty and 324 clocks. It also rewrites the period register at a boundary. A design that reloaded the period only at the wrap would then run one period at the old length. A second reset mid-stream must clear both the phase and the period register.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int PHASE_W   = 32;
  localparam int ADDR_W    = 8;
  localparam int SAMP_W    = 8;
  localparam int CODE_W    = 10;
  localparam int CODE_POS  = 8;
  localparam int INC_SHIFT = 5;
  localparam int PER_W     = 8;
  localparam logic [PER_W-1:0] PER_RST = 8'h50;

  // one point of the sine cycle, scaled and offset, rounded to nearest
  function automatic logic [SAMP_W-1:0] wave_point(input int idx, input int depth,
                                                   input real mid, input real amp);
    real ang;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(depth);
    return SAMP_W'(int'(mid + amp * $sin(ang)));
  endfunction
endpackage

// File: rtl/dds_phase_accum.sv
module dds_phase_accum #(
  parameter int PHASE_W   = dds_pkg::PHASE_W,
  parameter int CODE_W    = dds_pkg::CODE_W,
  parameter int CODE_POS  = dds_pkg::CODE_POS,
  parameter int INC_SHIFT = dds_pkg::INC_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic               code_valid,
  input  logic [CODE_W-1:0]  code_data,
  output logic               code_ready,
  output logic [PHASE_W-1:0] phase
);
  logic [CODE_W-1:0]  hold_q;
  logic               full_q;
  logic [PHASE_W-1:0] fword_q;
  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] incr;

  assign code_ready = !full_q;
  assign incr       = (fword_q << INC_SHIFT) + PHASE_W'(1);
  assign phase      = acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      fword_q <= '0;
      acc_q   <= '0;
    end else begin
      if (step) begin
        acc_q <= acc_q + incr;
        if (full_q) fword_q <= PHASE_W'(hold_q) << CODE_POS;
      end
      if (code_valid && !full_q) begin
        hold_q <= code_data;
        full_q <= 1'b1;
      end else if (step) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int  ADDR_W   = dds_pkg::ADDR_W,
  parameter int  SAMP_W   = dds_pkg::SAMP_W,
  parameter real WAVE_MID = 126.0,
  parameter real WAVE_AMP = 115.0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [SAMP_W-1:0] sample
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMP_W-1:0] table_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_pt
    localparam logic [SAMP_W-1:0] PT = dds_pkg::wave_point(i, DEPTH, WAVE_MID, WAVE_AMP);
    assign table_w[i] = PT;
  end

  always_ff @(posedge clk) begin
    if (rst) sample <= '0;
    else     sample <= table_w[addr];
  end
endmodule

// File: rtl/dds_pwm_gen.sv
module dds_pwm_gen #(
  parameter int               PER_W   = dds_pkg::PER_W,
  parameter int               SAMP_W  = dds_pkg::SAMP_W,
  parameter logic [PER_W-1:0] PER_RST = dds_pkg::PER_RST
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 period_we,
  input  logic [PER_W-1:0]     period_din,
  input  logic [SAMP_W-1:0]    duty_in,
  output logic                 wrap,
  output logic                 start,
  output logic                 pwm,
  output logic [PER_W+1:0]     duty_now
);
  localparam int CNT_W = PER_W + 2;

  logic [PER_W-1:0] per_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_q;
  logic [CNT_W-1:0] last;
  logic             start_q;

  assign last     = {per_q, 2'b11};
  assign wrap     = (cnt_q >= last);
  assign pwm      = (cnt_q < duty_q);
  assign start    = start_q;
  assign duty_now = duty_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q   <= PER_RST;
      cnt_q   <= '0;
      duty_q  <= '0;
      start_q <= 1'b0;
    end else begin
      cnt_q   <= wrap ? '0 : cnt_q + CNT_W'(1);
      start_q <= wrap;
      if (wrap)      duty_q <= CNT_W'(duty_in);
      if (period_we) per_q  <= period_din;
    end
  end
endmodule

// File: rtl/dds_pwm_synth.sv
module dds_pwm_synth #(
  parameter int PHASE_W = dds_pkg::PHASE_W,
  parameter int ADDR_W  = dds_pkg::ADDR_W,
  parameter int SAMP_W  = dds_pkg::SAMP_W,
  parameter int CODE_W  = dds_pkg::CODE_W,
  parameter int PER_W   = dds_pkg::PER_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code_data,
  output logic              code_ready,
  input  logic              period_we,
  input  logic [PER_W-1:0]  period_din,
  output logic              pwm_out,
  output logic              square_out,
  output logic [ADDR_W-1:0] tbl_addr,
  output logic              period_start
);
  logic [PHASE_W-1:0] phase_w;
  logic [SAMP_W-1:0]  sample_w;
  logic [PER_W+1:0]   duty_w;
  logic               wrap_w;

  dds_phase_accum #(.PHASE_W(PHASE_W), .CODE_W(CODE_W)) u_acc (
    .clk(clk), .rst(rst), .step(wrap_w),
    .code_valid(code_valid), .code_data(code_data), .code_ready(code_ready),
    .phase(phase_w)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .clk(clk), .rst(rst), .addr(tbl_addr), .sample(sample_w)
  );

  dds_pwm_gen #(.PER_W(PER_W), .SAMP_W(SAMP_W)) u_pwm (
    .clk(clk), .rst(rst), .period_we(period_we), .period_din(period_din),
    .duty_in(sample_w), .wrap(wrap_w), .start(period_start), .pwm(pwm_out),
    .duty_now(duty_w)
  );

  assign tbl_addr   = phase_w[PHASE_W-1 -: ADDR_W];
  assign square_out = phase_w[PHASE_W-1];
endmodule

// File: rtl/dds_pwm_synth_chk.sv
module dds_pwm_synth_chk #(
  parameter int PHASE_W = dds_pkg::PHASE_W,
  parameter int DUTY_W  = dds_pkg::PER_W + 2
) (
  input logic               clk,
  input logic               rst,
  input logic               wrap,
  input logic               period_start,
  input logic [PHASE_W-1:0] acc,
  input logic [DUTY_W-1:0]  duty_act,
  input logic               code_valid,
  input logic               code_ready
);
  // R2: the start marker lasts a single clock
  a_r2_single_start: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  // R6: phase moves only on the period boundary
  a_r6_step_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(acc));

  // R6: every boundary moves the phase
  a_r6_never_stalls: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (acc != $past(acc)));

  // R4: duty holds inside a period
  a_r4_duty_holds: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(duty_act));

  // R7: holding stage busy after a transfer
  a_r7_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (code_valid && code_ready) |=> !code_ready);
endmodule

bind dds_pwm_synth dds_pwm_synth_chk u_chk (
  .clk(clk), .rst(rst), .wrap(wrap_w), .period_start(period_start),
  .acc(phase_w), .duty_act(duty_w), .code_valid(code_valid), .code_ready(code_ready)
);

// File: tb/test_dds_pwm_synth.sv
`timescale 1ns/1ps
module test_dds_pwm_synth;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       code_valid = 1'b0;
  logic [9:0] code_data = '0;
  logic       code_ready;
  logic       period_we = 1'b0;
  logic [7:0] period_din = '0;
  logic       pwm_out, square_out, period_start;
  logic [7:0] tbl_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_acc;
  int m_f, m_hold, prev_addr, len;
  bit m_held;

  // {code, periods}
  localparam int NVEC = 5;
  localparam int VEC [NVEC][2] = '{'{1023, 300}, '{0, 10}, '{300, 80}, '{5, 10}, '{800, 40}};

  always #2.5 clk = ~clk;

  dds_pwm_synth i_dds_pwm_synth (
    .clk(clk), .rst(rst), .code_valid(code_valid), .code_data(code_data),
    .code_ready(code_ready), .period_we(period_we), .period_din(period_din),
    .pwm_out(pwm_out), .square_out(square_out), .tbl_addr(tbl_addr),
    .period_start(period_start)
  );

  function automatic int exp_sample(input int a);
    real ang;
    ang = 2.0 * 3.14159265358979 * real'(a) / 256.0;
    return int'(126.0 + 115.0 * $sin(ang));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_f = 0; m_hold = 0; m_held = 0; prev_addr = 0; len = 324;
  endtask

  // entered at the negedge where period_start is high
  task automatic run_period(input bit send, input int code);
    int hi, exp_duty;
    m_acc = m_acc + ((32'(m_f) << 13) + 32'd1);
    if (m_held) begin m_f = m_hold; m_held = 0; end
    chk(tbl_addr == m_acc[31:24], "R6 address", tbl_addr, m_acc[31:24]);
    chk(square_out == m_acc[31], "R8 square", square_out, m_acc[31]);
    chk(code_ready == 1'b1, "R7 ready at boundary", code_ready, 1);
    exp_duty  = exp_sample(prev_addr);
    prev_addr = m_acc[31:24];
    hi = 0;
    for (int k = 0; k < len; k++) begin
      if (k == 1) period_we = 1'b0;
      if (send && k == 0) begin code_valid = 1'b1; code_data = 10'(code); end
      if (send && k == 1) begin
        chk(code_ready == 1'b0, "R7 busy after transfer", code_ready, 0);
        code_data = 10'(~code);
        m_hold = code; m_held = 1;
      end
      if (send && k == 4) code_valid = 1'b0;
      if (k > 0) chk(period_start == 1'b0, "R2 no start inside", period_start, 0);
      hi += int'(pwm_out);
      @(negedge clk);
    end
    chk(hi == exp_duty, "R3 R4 R5 duty", hi, exp_duty);
    chk(period_start == 1'b1, "R2 R9 period length", period_start, 1);
  endtask

  task automatic reset_and_first();
    int n, hi;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(tbl_addr == 0, "R1 addr", tbl_addr, 0);
    chk(pwm_out == 0, "R1 pwm", pwm_out, 0);
    chk(square_out == 0, "R1 square", square_out, 0);
    chk(code_ready == 1, "R1 ready", code_ready, 1);
    chk(period_start == 0, "R1 start", period_start, 0);
    rst = 1'b0;
    model_reset();
    n = 0; hi = 0;
    while (!period_start && n < 2000) begin
      hi += int'(pwm_out);
      n++;
      @(negedge clk);
    end
    chk(n == 324, "R1 R2 first period length", n, 324);
    chk(hi == 0, "R3 first period duty", hi, 0);
  endtask

  initial begin
    @(negedge clk);
    reset_and_first();
    run_period(0, 0);
    run_period(0, 0);
    // R9: shorten to P=63 (256 clocks) right at a boundary
    period_we = 1'b1; period_din = 8'd63; len = 256;
    run_period(0, 0);
    for (int v = 0; v < NVEC; v++) begin
      run_period(1, VEC[v][0]);
      for (int p = 1; p < VEC[v][1]; p++) run_period(0, 0);
    end
    // R1: reset mid-stream restores phase and period register
    @(posedge clk);
    @(negedge clk);
    reset_and_first();
    run_period(0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule